// File: doc/BRIEF.md
# Configuration Load Sequencer

This block runs the slave configuration sequence of a downstream programmable device. After a start pulse it checks that a target is present, raises an optional enable, releases the open-drain init line and pulses the active-low program output. It waits for the target to signal readiness on init, then streams the image bytes from a valid/ready source onto a byte-wide configuration data port. Finally it waits for the done status.

Both waits have their own timeout and their own failure code. The load ends with a one-cycle finish pulse and a 2-bit result code that stays valid until the next load. The init and done status inputs cross into the clock domain through two flops. The wait limits are parameters, so short limits can be used in simulation.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset the block is idle. busy_o=0, prog_no_o=1, en_o=0, ready_o=0 and cfg_we_o=0. init_oe_o=1, which means the init line is held low until the first load.
- R2: A start with present_i=0 ends the load at once with result code 1: busy_o is high for exactly one cycle, together with finish_o. prog_no_o, en_o and init_oe_o do not change.
- R3: In a load with a present target and en_use_i=1, en_o is high from the start edge until finish. It is low in the finish cycle for every outcome. With en_use_i=0, en_o stays low.
- R4: The first load with a present target releases init (init_oe_o=0) before prog_no_o falls. Init stays released afterwards.
- R5: prog_no_o is low for exactly PROG_HOLD cycles (default 20) in each load with a present target. It falls only right after an accepted start.
- R6: If init stays low after program is released, finish_o is seen INIT_TO+1 cycles after prog_no_o rises. The result code is 2 and no byte is written.
- R7: Each byte accepted while valid_i and ready_o are both high appears once, in order, on cfg_data_o with cfg_we_o high on the next cycle. Exactly len_i bytes are written. ready_o is low outside the data phase.
- R8: If done stays low after the last byte, finish_o is seen DONE_TO+1 cycles after the last write, where DONE_TO = 10 x INIT_TO. The result code is 3.
- R9: A load in which init and then done rise in time ends with result code 0.
- R10: busy_o is high from the accepted start until the one-cycle finish_o pulse and low right after it. Start pulses while busy are ignored, so each load gives exactly one finish.
- R11: With len_i=0, no byte is written. The block goes from the init wait straight to the done wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| present_i | input | 1 | Selected target is present |
| en_use_i | input | 1 | Drive the enable output during the load |
| len_i | input | LEN_W | Image length in bytes, taken at start |
| data_i | input | DW | Image byte |
| valid_i | input | 1 | Image byte valid |
| ready_o | output | 1 | Image byte accepted when high together with valid_i |
| en_o | output | 1 | Target enable |
| prog_no | output | 1 | Program, active low |
| init_oe_o | output | 1 | 1 drives the open-drain init line low, 0 releases it |
| init_i | input | 1 | Init status from the target |
| done_i | input | 1 | Done status from the target |
| cfg_data_o | output | DW | Configuration data |
| cfg_we_o | output | 1 | Configuration data write strobe |
| busy_o | output | 1 | Load in progress |
| finish_o | output | 1 | One-cycle end-of-load pulse |
| result_o | output | 2 | 0 ok, 1 no target, 2 init timeout, 3 done timeout |

## Verification
The stream path is tried with random lengths from 0 to 24, random byte values and random gaps in valid_i. This shows whether bytes are lost, repeated or reordered, and whether the counter stops at the right byte. The target model raises init and done after random delays, or never. This separates the four result codes and shows that a late but in-time status is still accepted. Directed loads cover the absent target, the zero-length image, enable off, and start pulses during a load. The two timeouts are timed exactly against the program release and against the last write.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WINIT, ST_DATA, ST_WDONE, ST_FIN
  } state_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NOTGT  = 2'd1,
    RES_NOINIT = 2'd2,
    RES_NODONE = 2'd3
  } result_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int DW        = 8,
  parameter int PROG_HOLD = 20,
  parameter int INIT_TO   = 10000000,
  parameter int DONE_MULT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             present_i,
  input  logic             en_use_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             en_o,
  output logic             prog_no,
  output logic             init_oe_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic [DW-1:0]    cfg_data_o,
  output logic             cfg_we_o,
  output logic             busy_o,
  output logic             finish_o,
  output logic [1:0]       result_o
);
  localparam int DONE_TO = INIT_TO * DONE_MULT;
  localparam int HW      = $clog2(PROG_HOLD + 1);

  state_e           st_q;
  result_e          res_q;
  logic [LEN_W-1:0] left_q;
  logic [HW-1:0]    hold_q;
  logic             en_q, rel_q, we_q;
  logic [DW-1:0]    dat_q;
  logic             init_s, done_s, init_exp, done_exp, fire;

  cfg_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_i}),
    .q_o   ({done_s, init_s})
  );

  cfg_wait_timer #(.LIMIT(INIT_TO)) u_init_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q != ST_WINIT),
    .expired_o(init_exp)
  );

  cfg_wait_timer #(.LIMIT(DONE_TO)) u_done_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q != ST_WDONE),
    .expired_o(done_exp)
  );

  assign ready_o = (st_q == ST_DATA);
  assign fire    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_OK;
      left_q <= '0;
      hold_q <= '0;
      en_q   <= 1'b0;
      rel_q  <= 1'b0;
      we_q   <= 1'b0;
      dat_q  <= '0;
    end else begin
      we_q <= fire;
      if (fire) dat_q <= data_i;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (!present_i) begin
            res_q <= RES_NOTGT;
            st_q  <= ST_FIN;
          end else begin
            en_q   <= en_use_i;
            rel_q  <= 1'b1;
            left_q <= len_i;
            hold_q <= '0;
            st_q   <= ST_PROG;
          end
        end
        ST_PROG: begin
          hold_q <= hold_q + 1'b1;
          if (hold_q == HW'(PROG_HOLD - 1)) st_q <= ST_WINIT;
        end
        ST_WINIT: begin
          if (init_s) st_q <= (left_q == '0) ? ST_WDONE : ST_DATA;
          else if (init_exp) begin
            res_q <= RES_NOINIT;
            en_q  <= 1'b0;
            st_q  <= ST_FIN;
          end
        end
        ST_DATA: if (fire) begin
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) st_q <= ST_WDONE;
        end
        ST_WDONE: begin
          if (done_s) begin
            res_q <= RES_OK;
            en_q  <= 1'b0;
            st_q  <= ST_FIN;
          end else if (done_exp) begin
            res_q <= RES_NODONE;
            en_q  <= 1'b0;
            st_q  <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign finish_o   = (st_q == ST_FIN);
  assign prog_no    = (st_q != ST_PROG);
  assign init_oe_o  = !rel_q;
  assign en_o       = en_q;
  assign cfg_we_o   = we_q;
  assign cfg_data_o = dat_q;
  assign result_o   = res_q;

  assert_absent_at_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_o && result_o == RES_NOTGT) |-> $past(!busy_o));
  assert_en_low_fin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> !en_o);
  assert_init_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !init_oe_o);
  assert_prog_after_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_no) |-> $past(start_i));
  assert_we_after_hs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> $past(valid_i));
  assert_no_ready_in_prog_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !ready_o);
  assert_fin_ends_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !busy_o);
  assert_busy_from_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/cfg_load_seq_test.sv
module cfg_load_seq_test;
  localparam int LEN_W = 16;
  localparam int PROG_HOLD = 20;
  localparam int INIT_TO = 40;
  localparam int DONE_TO = INIT_TO * 10;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, present_i = 0, en_use_i = 0, valid_i = 0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0] data_i = '0;
  logic init_i = 0, done_i = 0;
  logic ready_o, en_o, prog_no, init_oe_o, cfg_we_o, busy_o, finish_o;
  logic [7:0] cfg_data_o;
  logic [1:0] result_o;

  always #2 clk_i = ~clk_i;

  cfg_load_seq #(.LEN_W(LEN_W), .DW(8), .PROG_HOLD(PROG_HOLD), .INIT_TO(INIT_TO),
                 .DONE_MULT(10)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .present_i(present_i),
    .en_use_i(en_use_i), .len_i(len_i), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .en_o(en_o), .prog_no(prog_no), .init_oe_o(init_oe_o),
    .init_i(init_i), .done_i(done_i), .cfg_data_o(cfg_data_o), .cfg_we_o(cfg_we_o),
    .busy_o(busy_o), .finish_o(finish_o), .result_o(result_o));

  int checks = 0, errors = 0;
  logic [7:0] img [0:63];
  int img_len = 0, src_idx = 0, wr_idx = 0, data_bad = 0;
  int fin_cnt = 0, fin_res = 0, fin_rel = 0, fin_we = 0;
  int since_rel = 0, since_we = 0, low_run = 0, last_low = 0, low_total = 0;
  int tgt_init = -1, tgt_done = -1, en_bad = 0, busy_cycles = 0;
  bit released = 0, prev_prog = 1, exp_en = 0, fired = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_result(bit pres, int idly, int ddly);
    if (!pres) return 1;
    if (idly < 0) return 2;
    if (ddly < 0) return 3;
    return 0;
  endfunction

  always @(posedge clk_i) fired <= valid_i && ready_o;

  // monitor, target model and byte source
  always @(negedge clk_i) if (rst_ni) begin
    if (!prog_no) begin
      low_run++; low_total++;
      init_i = 0; done_i = 0; released = 0;
    end else if (!prev_prog) begin
      last_low = low_run; low_run = 0; since_rel = 0; since_we = 0; released = 1;
    end else since_rel++;
    prev_prog = prog_no;
    if (released && tgt_init >= 0 && since_rel >= tgt_init) init_i = 1;
    if (cfg_we_o) begin
      if (wr_idx >= img_len || cfg_data_o !== img[wr_idx]) data_bad++;
      wr_idx++; since_we = 0;
    end else since_we++;
    if (released && init_i && wr_idx == img_len && tgt_done >= 0 && since_we >= tgt_done)
      done_i = 1;
    if (busy_o) busy_cycles++;
    if (busy_o && !finish_o && en_o !== exp_en) en_bad++;
    if ((finish_o || !busy_o) && en_o) en_bad++;
    if (finish_o) begin
      fin_cnt++; fin_res = result_o; fin_rel = since_rel; fin_we = since_we;
    end
    if (fired) src_idx++;
    if (src_idx < img_len) begin
      if (fired || !valid_i) begin
        valid_i = ($urandom % 4) != 0;
        data_i = img[src_idx];
      end
    end else valid_i = 0;
  end

  task automatic run_load(bit pres, bit enu, int len, int idly, int ddly, bit poke, string tag);
    int n = 0, er, ew, low0, oe0;
    @(posedge clk_i); #1;
    for (int i = 0; i < len; i++) img[i] = 8'($urandom);
    img_len = len; src_idx = 0; wr_idx = 0; data_bad = 0; fin_cnt = 0; valid_i = 0;
    tgt_init = idly; tgt_done = ddly; en_bad = 0; busy_cycles = 0;
    exp_en = pres && enu; low0 = low_total; oe0 = init_oe_o;
    present_i = pres; en_use_i = enu; len_i = LEN_W'(len);
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    if (poke) begin
      repeat (5) @(negedge clk_i);
      start_i = 1; @(negedge clk_i); start_i = 0;
      repeat (PROG_HOLD + 10) @(negedge clk_i);
      start_i = 1; @(negedge clk_i); start_i = 0;
    end
    while (fin_cnt == 0 && n < 3000) begin @(negedge clk_i); n++; end
    repeat (8) @(negedge clk_i);
    er = exp_result(pres, idly, ddly);
    ew = (er == 0 || er == 3) ? len : 0;
    chk(n < 3000, "R10", {tag, " watchdog"}, n, 0);
    chk(fin_cnt == 1, "R10", {tag, " finish count"}, fin_cnt, 1);
    chk(!busy_o, "R10", {tag, " busy after finish"}, busy_o, 0);
    chk(fin_res == er, er == 0 ? "R9" : er == 1 ? "R2" : er == 2 ? "R6" : "R8",
        {tag, " result"}, fin_res, er);
    chk(wr_idx == ew && data_bad == 0, len == 0 ? "R11" : "R7",
        {tag, " bytes written/bad"}, wr_idx * 1000 + data_bad, ew * 1000);
    chk(en_bad == 0, "R3", {tag, " enable"}, en_bad, 0);
    if (!pres) begin
      chk(low_total == low0 && init_oe_o == oe0, "R2", {tag, " pins untouched"},
          low_total - low0, 0);
      chk(busy_cycles == 1, "R2", {tag, " busy cycles"}, busy_cycles, 1);
    end else begin
      chk(last_low == PROG_HOLD, "R5", {tag, " prog low cycles"}, last_low, PROG_HOLD);
      chk(init_oe_o == 0, "R4", {tag, " init released"}, init_oe_o, 0);
    end
    if (er == 2) chk(fin_rel == INIT_TO + 1, "R6", {tag, " init timeout"}, fin_rel, INIT_TO + 1);
    if (er == 3 && len > 0)
      chk(fin_we == DONE_TO + 1, "R8", {tag, " done timeout"}, fin_we, DONE_TO + 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && prog_no == 1 && en_o == 0, "R1", "reset busy/prog/en",
        {busy_o, prog_no, en_o}, 3'b010);
    chk(ready_o == 0 && cfg_we_o == 0, "R1", "reset ready/we", {ready_o, cfg_we_o}, 0);
    chk(init_oe_o == 1, "R1", "reset init held", init_oe_o, 1);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    run_load(0, 1, 5, 3, 3, 0, "absent_R2");
    run_load(1, 1, 6, 5, 4, 0, "ok_en_R3");
    run_load(1, 0, 3, 30, 20, 0, "ok_noen_R9");
    run_load(1, 1, 4, -1, 5, 0, "noinit_R6");
    run_load(1, 1, 4, 3, -1, 0, "nodone_R8");
    run_load(1, 1, 0, 4, 6, 0, "zero_R11");
    run_load(1, 1, 0, 4, -1, 0, "zero_nodone_R11");
    run_load(1, 1, 12, 2, 2, 1, "poke_R10");
    for (int k = 0; k < 14; k++) begin
      bit p = ($urandom % 10) != 0;
      int il = ($urandom % 10 == 0) ? -1 : 1 + int'($urandom % 30);
      int dl = ($urandom % 10 == 0) ? -1 : 1 + int'($urandom % 40);
      run_load(p, 1'($urandom), int'($urandom % 25), il, dl, 0, "random_R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL R10 global watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule